// File: doc/BRIEF.md
# Disk Channel Interrupt Status Controller

This block gathers the two interrupt causes of a single disk channel: the attached drive signalling completion, and the DMA engine reporting a memory or bus fault. Each cause latches a pending bit. Software clears a pending bit by writing a one to it. A per-source enable mask, set and cleared through two separate words, gates the pending bits onto one level-sensitive interrupt line.

On a memory fault the block also records the failing bus address as two data words. The record is taken only on the first fault and is held until software acknowledges that fault. The drive's own status register is outside this block. A read of it appears here as a strobe together with the value returned. If that value shows the drive as not busy or in error, both pending bits clear as a side effect. A mask bit in the drive's control byte keeps drive events from being recorded.

Software reaches the block through a synchronous word-indexed read/write port. Read data appears one cycle after the request.

Top module: `dsk_irq_ctrl`

## Requirements
- R1: After reset the pending bits, the enable mask, both captured address words, the read data and `irq_o` are all zero.
- R2: Writing to word 5 sets each enable bit whose write-data bit is 1. Writing to word 7 clears each enable bit whose write-data bit is 1. A read of either word returns the enable mask in bits [1:0], with bit 0 for the drive and bit 1 for the memory fault.
- R3: A cycle with `dev_irq_i` high sets pending bit 0, and a cycle with `mem_err_i` high sets pending bit 1. Both bits read at word 3, bits [1:0].
- R4: A write to word 3 clears each pending bit whose write-data bit is 1. A 0 in a write-data bit leaves that pending bit unchanged.
- R5: When `mem_err_i` is high and pending bit 1 is clear, the low half of `mem_err_addr_i` is stored and reads at word 0. The high half is stored and reads at word 1.
- R6: While pending bit 1 is set, further memory faults leave both captured address words unchanged.
- R7: While bit 1 of `dev_ctl_i` is 1, `dev_irq_i` does not set pending bit 0.
- R8: A cycle with `drive_stat_rd_i` high and any of bits 0, 4 or 6 of `drive_stat_i` set clears both pending bits. Any other value has no effect.
- R9: When a set event and a clear (from a write or from a status read) hit the same pending bit in the same cycle, the bit ends up set.
- R10: `irq_o` is 1 exactly when some pending bit has its enable bit set. It stays high until that condition ends.
- R11: Read data is registered and appears one cycle after a read request. Word indices other than 0, 1, 3, 5 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the request |
| dev_irq_i | input | 1 | Drive interrupt event |
| dev_ctl_i | input | 8 | Drive control byte; bit 1 masks drive events |
| drive_stat_rd_i | input | 1 | Strobe: the drive status register is being read |
| drive_stat_i | input | 8 | Value returned by that status read |
| mem_err_i | input | 1 | Memory or bus fault event from the DMA engine |
| mem_err_addr_i | input | 64 | Failing bus address at the fault |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that the event inputs are single-cycle strobes sampled on the clock. They also assume the bus carries at most one request per cycle. The properties on clearing are stated only for cycles that carry no competing set event, because a set event takes priority over a clear. The stimulus drives every input on the falling edge. It holds each strobe for exactly one cycle, and it makes set and clear coincide only in the cases written to test that priority.

// File: rtl/dsk_irq_pkg.sv
package dsk_irq_pkg;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_DEV = 0;
  localparam int unsigned SRC_ERR = 1;

  localparam logic [3:0] IDX_ERR_LO = 4'd0;
  localparam logic [3:0] IDX_ERR_HI = 4'd1;
  localparam logic [3:0] IDX_STAT   = 4'd3;
  localparam logic [3:0] IDX_EN_SET = 4'd5;
  localparam logic [3:0] IDX_EN_CLR = 4'd7;

  localparam logic [7:0] DRV_READY_MASK = 8'h51;
  localparam int unsigned DRV_MASK_BIT  = 1;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/dsk_irq_pend.sv
module dsk_irq_pend #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar k = 0; k < N; k++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_o[k] <= 1'b0;
      else if (set_i[k])  pend_o[k] <= 1'b1;  // set has priority
      else if (clr_i[k])  pend_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/dsk_irq_errcap.sv
module dsk_irq_errcap #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CAP_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_en_i,
  input  logic [CAP_W-1:0]  addr_i,
  output logic [CAP_W-1:0]  cap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cap_o <= '0;
    else if (cap_en_i) cap_o <= addr_i;
  end
endmodule

// File: rtl/dsk_irq_regif.sv
module dsk_irq_regif
  import dsk_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned CAP_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  src_vec_t          pend_i,
  input  src_vec_t          en_i,
  input  logic [CAP_W-1:0]  cap_i,
  output src_vec_t          stat_clr_o,
  output src_vec_t          en_set_o,
  output src_vec_t          en_clr_o
);
  logic wr, rd;
  logic [DATA_W-1:0] rmux;
  logic unused_wdata;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;
  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_SRC];

  assign stat_clr_o = (wr && addr_i == ADDR_W'(IDX_STAT))   ? wdata_i[NUM_SRC-1:0] : '0;
  assign en_set_o   = (wr && addr_i == ADDR_W'(IDX_EN_SET)) ? wdata_i[NUM_SRC-1:0] : '0;
  assign en_clr_o   = (wr && addr_i == ADDR_W'(IDX_EN_CLR)) ? wdata_i[NUM_SRC-1:0] : '0;

  always_comb begin
    rmux = '0;
    unique case (addr_i)
      ADDR_W'(IDX_ERR_LO): rmux = cap_i[DATA_W-1:0];
      ADDR_W'(IDX_ERR_HI): rmux = cap_i[CAP_W-1:DATA_W];
      ADDR_W'(IDX_STAT):   rmux[NUM_SRC-1:0] = pend_i;
      ADDR_W'(IDX_EN_SET),
      ADDR_W'(IDX_EN_CLR): rmux[NUM_SRC-1:0] = en_i;
      default:             rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rmux;
  end
endmodule

// File: rtl/dsk_irq_ctrl.sv
module dsk_irq_ctrl
  import dsk_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned CAP_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              dev_irq_i,
  input  logic [7:0]        dev_ctl_i,
  input  logic              drive_stat_rd_i,
  input  logic [7:0]        drive_stat_i,
  input  logic              mem_err_i,
  input  logic [CAP_W-1:0]  mem_err_addr_i,
  output logic              irq_o
);
  src_vec_t pend_q, en_q, set_ev, clr_ev, stat_clr, en_set, en_clr;
  logic [CAP_W-1:0] cap_q;
  logic side_clr;
  logic unused_ctl;

  assign unused_ctl = ^{dev_ctl_i[7:DRV_MASK_BIT+1], dev_ctl_i[DRV_MASK_BIT-1:0]};

  // drive status read reporting not-busy/error acknowledges everything
  assign side_clr = drive_stat_rd_i & |(drive_stat_i & DRV_READY_MASK);

  always_comb begin
    set_ev          = '0;
    set_ev[SRC_DEV] = dev_irq_i & ~dev_ctl_i[DRV_MASK_BIT];
    set_ev[SRC_ERR] = mem_err_i;
  end

  assign clr_ev = stat_clr | {NUM_SRC{side_clr}};

  dsk_irq_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (bus_req_i),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .pend_i     (pend_q),
    .en_i       (en_q),
    .cap_i      (cap_q),
    .stat_clr_o (stat_clr),
    .en_set_o   (en_set),
    .en_clr_o   (en_clr)
  );

  dsk_irq_pend #(.N(NUM_SRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_ev),
    .clr_i  (clr_ev),
    .pend_o (pend_q)
  );

  dsk_irq_pend #(.N(NUM_SRC)) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (en_set),
    .clr_i  (en_clr),
    .pend_o (en_q)
  );

  // address record taken only when no fault is outstanding
  dsk_irq_errcap #(.DATA_W(DATA_W)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_en_i (mem_err_i & ~pend_q[SRC_ERR]),
    .addr_i   (mem_err_addr_i),
    .cap_o    (cap_q)
  );

  assign irq_o = |(pend_q & en_q);
endmodule

// File: rtl/dsk_irq_chk.sv
module dsk_irq_chk #(
  parameter int unsigned CAP_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dev_irq_i,
  input logic [7:0]       dev_ctl_i,
  input logic             mem_err_i,
  input logic             drive_stat_rd_i,
  input logic [7:0]       drive_stat_i,
  input logic [1:0]       pend_q,
  input logic [CAP_W-1:0] cap_q,
  input logic             irq_o
);
  assert_err_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_err_i |=> pend_q[1]);

  assert_cap_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q[1] |=> $stable(cap_q));

  assert_mask_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_ctl_i[1] && !pend_q[0]) |=> !pend_q[0]);

  assert_side_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_stat_rd_i && (drive_stat_i & 8'h51) != 8'h00 && !dev_irq_i && !mem_err_i)
    |=> pend_q == 2'b00);

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_irq_i && !dev_ctl_i[1]) |=> pend_q[0]);

  assert_irq_needs_pend_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_q != 2'b00);
endmodule

bind dsk_irq_ctrl dsk_irq_chk #(.CAP_W(CAP_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .dev_irq_i       (dev_irq_i),
  .dev_ctl_i       (dev_ctl_i),
  .mem_err_i       (mem_err_i),
  .drive_stat_rd_i (drive_stat_rd_i),
  .drive_stat_i    (drive_stat_i),
  .pend_q          (pend_q),
  .cap_q           (cap_q),
  .irq_o           (irq_o)
);

// File: tb/dsk_irq_ctrl_tb.sv
module dsk_irq_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        dev_irq_i = 1'b0;
  logic [7:0]  dev_ctl_i = '0;
  logic        drive_stat_rd_i = 1'b0;
  logic [7:0]  drive_stat_i = '0;
  logic        mem_err_i = 1'b0;
  logic [63:0] mem_err_addr_i = '0;
  logic        irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  dsk_irq_ctrl u_dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_req_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_req_i = 0; bus_we_i = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_req_i = 1; bus_we_i = 0; bus_addr_i = a;
    @(negedge clk_i);
    d = bus_rdata_o;
    bus_req_i = 0;
  endtask

  task automatic ev(input bit dev, input bit err, input logic [63:0] a);
    @(negedge clk_i);
    dev_irq_i = dev; mem_err_i = err; mem_err_addr_i = a;
    @(negedge clk_i);
    dev_irq_i = 0; mem_err_i = 0;
  endtask

  task automatic stat_rd(input logic [7:0] v);
    @(negedge clk_i);
    drive_stat_rd_i = 1; drive_stat_i = v;
    @(negedge clk_i);
    drive_stat_rd_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, lo, hi;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset state
    check("R1 irq", irq_o, 0);
    check("R1 rdata", bus_rdata_o, 0);
    rd(4'd3, d); check("R1 status", d, 0);
    rd(4'd5, d); check("R1 enable", d, 0);
    rd(4'd0, d); check("R1 cap lo", d, 0);
    rd(4'd1, d); check("R1 cap hi", d, 0);

    // R2 enable set/clear
    wr(4'd5, 32'h3); rd(4'd5, d); check("R2 set both", d, 3);
    wr(4'd7, 32'h1); rd(4'd7, d); check("R2 clear bit0", d, 2);
    wr(4'd5, 32'h1); rd(4'd5, d); check("R2 set again", d, 3);

    // R3 / R10 device event
    ev(1, 0, '0);
    rd(4'd3, d); check("R3 dev pending", d, 1);
    check("R10 irq level", irq_o, 1);
    repeat (5) @(negedge clk_i);
    check("R10 irq held", irq_o, 1);

    // R4 W1C with zero bit no effect
    wr(4'd3, 32'h2); rd(4'd3, d); check("R4 zero no effect", d, 1);
    wr(4'd3, 32'h3); rd(4'd3, d); check("R4 cleared", d, 0);
    check("R4 irq low", irq_o, 0);

    // R5 capture, R6 freeze
    ev(0, 1, 64'h1234_5678_9abc_def0);
    rd(4'd3, d); check("R3 err pending", d, 2);
    rd(4'd0, lo); check("R5 cap lo", lo, 32'h9abc_def0);
    rd(4'd1, hi); check("R5 cap hi", hi, 32'h1234_5678);
    ev(0, 1, 64'hffff_0000_5555_aaaa);
    rd(4'd0, lo); check("R6 frozen lo", lo, 32'h9abc_def0);
    rd(4'd1, hi); check("R6 frozen hi", hi, 32'h1234_5678);
    wr(4'd3, 32'h2);
    ev(0, 1, 64'h0000_0042_0000_0077);
    rd(4'd0, lo); check("R5 recapture lo", lo, 32'h77);
    rd(4'd1, hi); check("R5 recapture hi", hi, 32'h42);
    wr(4'd3, 32'h3);

    // R7 mask
    dev_ctl_i = 8'h02;
    ev(1, 0, '0);
    rd(4'd3, d); check("R7 masked", d, 0);
    check("R7 irq", irq_o, 0);
    dev_ctl_i = 8'hFD;
    ev(1, 0, '0);
    rd(4'd3, d); check("R7 other ctl bits", d, 1);
    dev_ctl_i = 8'h00;
    wr(4'd3, 32'h3);

    // R8 sweep of status values
    for (int v = 0; v < 256; v++) begin
      ev(1, 1, 64'(v));
      stat_rd(8'(v));
      rd(4'd3, d);
      check("R8 side clear", d, ((v & 8'h51) != 0) ? 32'd0 : 32'd3);
    end
    wr(4'd3, 32'h3);

    // R9 set beats W1C write
    ev(0, 1, '0);
    @(negedge clk_i);
    bus_req_i = 1; bus_we_i = 1; bus_addr_i = 4'd3; bus_wdata_i = 32'h3; dev_irq_i = 1;
    @(negedge clk_i);
    bus_req_i = 0; bus_we_i = 0; dev_irq_i = 0;
    rd(4'd3, d); check("R9 set wins write", d, 1);
    // R9 set beats side clear
    ev(1, 1, '0);
    @(negedge clk_i);
    drive_stat_rd_i = 1; drive_stat_i = 8'h40; mem_err_i = 1;
    @(negedge clk_i);
    drive_stat_rd_i = 0; mem_err_i = 0;
    rd(4'd3, d); check("R9 set wins side clear", d, 2);
    wr(4'd3, 32'h3);

    // R10 sweep of enable x pending
    for (int e = 0; e < 4; e++) begin
      for (int p = 0; p < 4; p++) begin
        wr(4'd3, 32'h3);
        wr(4'd7, 32'h3);
        wr(4'd5, 32'(e));
        if (p != 0) ev(p[0], p[1], '0);
        @(negedge clk_i);
        check("R10 irq", irq_o, ((e & p) != 0) ? 1 : 0);
      end
    end

    // R11 unmapped words and latency
    wr(4'd5, 32'h3);
    foreach (d[i]) ;
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 1 && a != 3 && a != 5 && a != 7) begin
        rd(4'(a), d); check("R11 unmapped", d, 0);
      end
    end
    @(negedge clk_i);
    bus_req_i = 1; bus_we_i = 0; bus_addr_i = 4'd5;
    #1 check("R11 not yet", bus_rdata_o, 0);
    @(negedge clk_i);
    bus_req_i = 0;
    check("R11 one cycle", bus_rdata_o, 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule